// File: doc/BRIEF.md
# SIMT Execution Mask Controller

This block keeps the per-lane execution mask for a group of SIMD lanes that share one scalar controller. A lane does vector work only while its mask bit is set. The controller applies structured control-flow operations to that mask: entering an if region, switching to the else side, closing the region, collecting loop-exit lanes, and going back to the top of a loop. Each operation takes one cycle.

The caller keeps every saved mask in its own scalar register and passes it back as an operand when it is needed. Each operation returns a saved-mask result, and the controller raises a flag that the sequencer uses to skip an empty region or to repeat a loop. The lane count is a parameter and may be 32 or 64. Operand and result ports are always 64 bits wide, and only the low lane-count bits take part in the mask algebra.

Operations are chosen with a one-hot select, qualified by a valid strobe. The mask, the saved-mask result and both branch flags are registered.

Top module: `exec_mask_ctrl`

## Requirements
- R1: After reset the mask has its low LANES bits set and all other bits clear, the saved result is zero, and both branch flags are low.
- R2: Op select bit 0 (if) writes mask = mask AND cond. The saved result becomes the lanes that were active before and are now off (old mask AND NOT cond).
- R3: Op select bit 1 (simple if) writes the same new mask as R2. The saved result is the whole mask from before the operation.
- R4: Op select bit 2 (else) with operand S returns the mask from before the operation as the saved result. The new mask is S AND NOT the old mask.
- R5: Op select bit 3 (end if) writes mask = mask OR saved operand. The saved result is unchanged.
- R6: Op select bit 4 (break) leaves the mask unchanged. The saved result becomes (mask AND cond) OR break operand. When cond_masked is high, the AND with the mask is skipped and cond is used as given.
- R7: Op select bit 5 (loop) writes mask = mask AND NOT break operand. The branch-if-nonzero flag is then high exactly when the new mask is nonzero.
- R8: After an if, simple if or else, the branch-if-zero flag is high exactly when the new mask is zero. Both flags are low in the cycle after any other operation, an idle cycle or an ignored select. The two flags are never high together.
- R9: A cycle with op_valid low, or with a select that does not have exactly one bit set, leaves the mask and the saved result unchanged.
- R10: With LANES = 32, operand bits 63:32 are ignored, and bits 63:32 of the mask and of the saved result always read zero.
- R11: An operation presented while reset is asserted has no effect. The state after reset is as in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe |
| op_sel | input | 6 | One-hot operation select (bit order listed in the requirements) |
| cond | input | 64 | Per-lane condition for if, simple if and break |
| saved_in | input | 64 | Saved-mask operand for else and end if |
| brk_in | input | 64 | Break accumulator operand for break and loop |
| cond_masked | input | 1 | Condition is already limited to active lanes, so the AND is skipped |
| exec_mask | output | 64 | Current execution mask |
| saved_out | output | 64 | Saved-mask or break result of the last operation |
| br_zero | output | 1 | Branch-if-mask-zero flag |
| br_nonzero | output | 1 | Branch-if-mask-nonzero flag |

## Verification
Two functions can fall in the same cycle. An operation can arrive while reset is held, and a strobe can carry a select with two operation bits set at once. The bench provokes the first by raising op_valid with an if select while rst_n is low, then checks that the released state equals the reset state. It provokes the second by driving an if and a simple-if bit together after a known mask, then checks that the mask and saved result hold and that both flags are low. A second instance built for 32 lanes receives operands with set upper bits, and its upper result bits are checked to stay zero.

// File: rtl/exec_mask_ctrl.sv
module exec_mask_ctrl #(
  parameter int LANES = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [5:0]  op_sel,
  input  logic [63:0] cond,
  input  logic [63:0] saved_in,
  input  logic [63:0] brk_in,
  input  logic        cond_masked,
  output logic [63:0] exec_mask,
  output logic [63:0] saved_out,
  output logic        br_zero,
  output logic        br_nonzero
);

  localparam logic [63:0] LMASK = (LANES >= 64) ? {64{1'b1}} : ((64'd1 << LANES) - 64'd1);

  logic [63:0] c_m, s_m, b_m, and_c, or_s, brk_acc;
  logic [63:0] nxt_exec, nxt_saved;
  logic        nxt_bz, nxt_bnz, legal;

  assign c_m   = cond & LMASK;
  assign s_m   = saved_in & LMASK;
  assign b_m   = brk_in & LMASK;
  assign legal = op_valid && $onehot(op_sel);

  assign and_c   = exec_mask & c_m;
  assign or_s    = exec_mask | s_m;
  assign brk_acc = (cond_masked ? c_m : and_c) | b_m;

  always_comb begin
    nxt_exec  = exec_mask;
    nxt_saved = saved_out;
    nxt_bz    = 1'b0;
    nxt_bnz   = 1'b0;
    if (legal) begin
      case (op_sel)
        6'b000001: begin
          nxt_exec  = and_c;
          nxt_saved = and_c ^ exec_mask;
          nxt_bz    = (and_c == 64'd0);
        end
        6'b000010: begin
          nxt_exec  = and_c;
          nxt_saved = exec_mask;
          nxt_bz    = (and_c == 64'd0);
        end
        6'b000100: begin
          nxt_saved = or_s & exec_mask;
          nxt_exec  = or_s ^ (or_s & exec_mask);
          nxt_bz    = ((or_s ^ (or_s & exec_mask)) == 64'd0);
        end
        6'b001000: begin
          nxt_exec = or_s;
        end
        6'b010000: begin
          nxt_saved = brk_acc;
        end
        6'b100000: begin
          nxt_exec = exec_mask & ~b_m;
          nxt_bnz  = ((exec_mask & ~b_m) != 64'd0);
        end
        default: begin
          nxt_exec = exec_mask;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exec_mask  <= LMASK;
      saved_out  <= 64'd0;
      br_zero    <= 1'b0;
      br_nonzero <= 1'b0;
    end else begin
      exec_mask  <= nxt_exec & LMASK;
      saved_out  <= nxt_saved & LMASK;
      br_zero    <= nxt_bz;
      br_nonzero <= nxt_bnz;
    end
  end

endmodule

// File: rtl/exec_mask_ctrl_chk.sv
module exec_mask_ctrl_chk #(
  parameter int LANES = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [5:0]  op_sel,
  input logic [63:0] cond,
  input logic [63:0] saved_in,
  input logic [63:0] brk_in,
  input logic        cond_masked,
  input logic [63:0] exec_mask,
  input logic [63:0] saved_out,
  input logic        br_zero,
  input logic        br_nonzero
);

  localparam logic [63:0] LMASK = (LANES >= 64) ? {64{1'b1}} : ((64'd1 << LANES) - 64'd1);

  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;

  a_r10_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ((exec_mask | saved_out) & ~LMASK) == 64'd0);

  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(br_zero && br_nonzero));

  a_r2_if_mask: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_valid && op_sel == 6'b000001 |=>
      exec_mask == ($past(exec_mask) & $past(cond) & LMASK));

  a_r5_endif_grows: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_valid && op_sel == 6'b001000 |=>
      (exec_mask & $past(exec_mask)) == $past(exec_mask) && $stable(saved_out));

  a_r7_loop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_valid && op_sel == 6'b100000 |=>
      (exec_mask & $past(brk_in) & LMASK) == 64'd0 && br_nonzero == (exec_mask != 64'd0));

  a_r9_ignored_hold: assert property (@(posedge clk) disable iff (!rst_n)
    live && !(op_valid && $onehot(op_sel)) |=>
      $stable(exec_mask) && $stable(saved_out) && !br_zero && !br_nonzero);

  a_r6_break_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
    live && op_valid && op_sel == 6'b010000 |=> $stable(exec_mask));

endmodule

bind exec_mask_ctrl exec_mask_ctrl_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
  .cond(cond), .saved_in(saved_in), .brk_in(brk_in), .cond_masked(cond_masked),
  .exec_mask(exec_mask), .saved_out(saved_out),
  .br_zero(br_zero), .br_nonzero(br_nonzero)
);

// File: tb/tb_exec_mask_ctrl.sv
module tb_exec_mask_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic [5:0] op_sel = 6'd0;
  logic [63:0] cond = 64'd0, saved_in = 64'd0, brk_in = 64'd0;
  logic cond_masked = 1'b0;
  logic [63:0] exec_mask, saved_out, exec32, saved32;
  logic br_zero, br_nonzero, bz32, bnz32;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  exec_mask_ctrl #(.LANES(64)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .cond(cond), .saved_in(saved_in), .brk_in(brk_in), .cond_masked(cond_masked),
    .exec_mask(exec_mask), .saved_out(saved_out), .br_zero(br_zero), .br_nonzero(br_nonzero));

  exec_mask_ctrl #(.LANES(32)) dut32 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .cond(cond), .saved_in(saved_in), .brk_in(brk_in), .cond_masked(cond_masked),
    .exec_mask(exec32), .saved_out(saved32), .br_zero(bz32), .br_nonzero(bnz32));

  typedef struct packed {
    logic [5:0]  sel;
    logic [63:0] c;
    logic [63:0] s;
    logic [63:0] b;
    logic        m;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6'b000001, 64'h00000000_FFFF0000, 64'h0, 64'h0, 1'b0},
    '{6'b000100, 64'h0, 64'hFFFFFFFF_0000FFFF, 64'h0, 1'b0},
    '{6'b001000, 64'h0, 64'h00000000_FFFF0000, 64'h0, 1'b0},
    '{6'b000010, 64'h0, 64'h0, 64'h0, 1'b0},
    '{6'b001000, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 1'b0},
    '{6'b010000, 64'h00000000_000000F0, 64'h0, 64'h1, 1'b0},
    '{6'b100000, 64'h0, 64'h0, 64'h00000000_000000F1, 1'b0},
    '{6'b010000, 64'h00000000_00000010, 64'h0, 64'h0, 1'b1},
    '{6'b100000, 64'h0, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 1'b0},
    '{6'b000001, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 64'h0, 1'b0},
    '{6'b001000, 64'h0, 64'hFFFFFFFF_FFFFFFFF, 64'h0, 1'b0},
    '{6'b000011, 64'h0, 64'h0, 64'h0, 1'b0}
  };

  logic [63:0] m_exec, m_saved;
  logic m_bz, m_bnz;

  function automatic string tag(input logic [5:0] s);
    case (s)
      6'b000001: return "R2";
      6'b000010: return "R3";
      6'b000100: return "R4";
      6'b001000: return "R5";
      6'b010000: return "R6";
      6'b100000: return "R7";
      default:   return "R9";
    endcase
  endfunction

  task automatic model(input logic [5:0] s, input logic [63:0] c, sv, b, input logic m);
    logic [63:0] old = m_exec;
    m_bz = 1'b0;
    m_bnz = 1'b0;
    case (s)
      6'b000001: begin m_exec = old & c; m_saved = old & ~c; m_bz = (m_exec == 0); end
      6'b000010: begin m_exec = old & c; m_saved = old; m_bz = (m_exec == 0); end
      6'b000100: begin m_exec = sv & ~old; m_saved = old; m_bz = (m_exec == 0); end
      6'b001000: m_exec = old | sv;
      6'b010000: m_saved = (m ? c : (old & c)) | b;
      6'b100000: begin m_exec = old & ~b; m_bnz = (m_exec != 0); end
      default: ;
    endcase
  endtask

  task automatic chk(input string r, input string what, input logic [63:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [5:0] s, input logic [63:0] c, sv, b, input logic m);
    op_valid = v; op_sel = s; cond = c; saved_in = sv; brk_in = b; cond_masked = m;
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; op_sel = 6'd0;
  endtask

  task automatic check_all(input string r);
    chk(r, "exec", exec_mask, m_exec);
    chk(r, "saved", saved_out, m_saved);
    chk(r, "br_zero", {63'd0, br_zero}, {63'd0, m_bz});
    chk(r, "br_nonzero", {63'd0, br_nonzero}, {63'd0, m_bnz});
  endtask

  initial begin
    #200000;
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_exec = {64{1'b1}}; m_saved = 64'd0; m_bz = 1'b0; m_bnz = 1'b0;
    check_all("R1");
    chk("R1", "exec32", exec32, 64'h00000000_FFFFFFFF);

    for (int i = 0; i < NV; i++) begin
      apply(1'b1, VECS[i].sel, VECS[i].c, VECS[i].s, VECS[i].b, VECS[i].m);
      model(VECS[i].sel, VECS[i].c, VECS[i].s, VECS[i].b, VECS[i].m);
      check_all(tag(VECS[i].sel));
    end

    // R9: valid low with a legal select
    apply(1'b0, 6'b000001, 64'h0, 64'h0, 64'h0, 1'b0);
    check_all("R9");

    // R8: flags drop after an idle cycle following a zero-mask if
    apply(1'b1, 6'b000001, 64'h0, 64'h0, 64'h0, 1'b0);
    model(6'b000001, 64'h0, 64'h0, 64'h0, 1'b0);
    check_all("R8");
    apply(1'b0, 6'b000000, 64'h0, 64'h0, 64'h0, 1'b0);
    model(6'b000000, 64'h0, 64'h0, 64'h0, 1'b0);
    check_all("R8");

    // R11: op held during reset has no effect
    @(negedge clk);
    rst_n = 1'b0;
    op_valid = 1'b1; op_sel = 6'b000001; cond = 64'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    op_valid = 1'b0; op_sel = 6'd0;
    @(negedge clk);
    m_exec = {64{1'b1}}; m_saved = 64'd0; m_bz = 1'b0; m_bnz = 1'b0;
    check_all("R11");
    chk("R11", "exec32", exec32, 64'h00000000_FFFFFFFF);

    // R10: 32-lane instance ignores upper operand bits
    apply(1'b1, 6'b000001, 64'hFFFF0000_0000FF00, 64'h0, 64'h0, 1'b0);
    chk("R10", "exec32", exec32, 64'h00000000_0000FF00);
    chk("R10", "saved32", saved32, 64'h00000000_FFFF00FF);
    chk("R10", "bz32", {63'd0, bz32}, 64'd0);
    apply(1'b1, 6'b001000, 64'h0, 64'hFFFFFFFF_00000001, 64'h0, 1'b0);
    chk("R10", "exec32", exec32, 64'h00000000_0000FF01);
    apply(1'b1, 6'b100000, 64'h0, 64'h0, 64'h00000000_0000FF01, 1'b0);
    chk("R10", "exec32", exec32, 64'h0);
    chk("R10", "bnz32", {63'd0, bnz32}, 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule